// File: doc/BRIEF.md
# Multi-Cycle Unsigned Multiply/Divide Unit

This block is a sequential arithmetic engine beside a CPU datapath. On a start strobe it captures an opcode and two unsigned operands and runs one of four operations: a short multiply (16 by 8 bits), a long multiply (24 by 16 bits), a short divide (16 by 8 bits) or a long divide (24 by 16 bits). Each opcode has its own fixed latency. The done pulse lands on the same cycle count every time, whatever the operand values, so the issuing pipeline can schedule writeback statically.

The datapath retires two operand bits per clock. Multiplies use shift-and-add and divides use restoring division. The first step runs on the same edge that accepts the command. The short multiply finishes its useful work before its latency expires, and the remaining steps shift in only zeros. Results sit in registers and hold until the next accepted command.

Top module: `muldiv_unit`

## Requirements
- R1: Opcode 2'b00 (short multiply) sets `product` to opa[15:0] × opb[7:0] with product[39:24] zero, and `done` is high in the 5th cycle after the start cycle.
- R2: Opcode 2'b01 (long multiply) sets `product` to opa × opb (40 bits), and `done` is high in the 12th cycle after the start cycle.
- R3: Opcode 2'b10 (short divide) sets quotient[15:0] to opa[15:0] / opb[7:0] and remainder[7:0] to the modulus, with quotient[23:16] and remainder[15:8] zero, and `done` is high in the 8th cycle after the start cycle.
- R4: Opcode 2'b11 (long divide) sets `quotient` to opa / opb and `remainder` to opa mod opb, and `done` is high in the 12th cycle after the start cycle.
- R5: `done` is high for exactly one cycle. `busy` is high from the cycle after the start cycle through the cycle before `done`, and is low while `done` is high. A start is accepted whenever `busy` is low, including in the `done` cycle.
- R6: A start raised while `busy` is high is ignored. The operands and opcode are captured in the start cycle, so changing them afterwards does not alter the running result or its timing.
- R7: A divide with a zero divisor (opb[7:0] for the short divide, opb for the long divide) sets `div_zero`, returns an all-ones quotient of the operation's width, and returns the dividend's low 8 or 16 bits as the remainder, in the normal latency. Any divide with a nonzero divisor clears `div_zero`.
- R8: With no accepted start, all result outputs hold their values. A multiply leaves `quotient`, `remainder` and `div_zero` unchanged, and a divide leaves `product` unchanged.
- R9: After synchronous reset, `busy`, `done`, `div_zero`, `product`, `quotient` and `remainder` are all zero.
- R10: The short operations ignore opa[23:16] and opb[15:8].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, accepted when busy is low |
| op | input | 2 | Operation select (00 mul short, 01 mul long, 10 div short, 11 div long) |
| opa | input | 24 | Multiplicand or dividend |
| opb | input | 16 | Multiplier or divisor |
| busy | output | 1 | An operation is in flight |
| done | output | 1 | One-cycle completion pulse |
| product | output | 40 | Multiply result |
| quotient | output | 24 | Divide quotient |
| remainder | output | 16 | Divide remainder |
| div_zero | output | 1 | Last divide had a zero divisor |

## Verification
The bench times `done` to the exact cycle for each opcode. A sequencer that is off by one, or that adds a load cycle before the first step, shows up as `done` one cycle late, or as a short divide missing its last quotient bits. Operands are scrambled right after the start cycle, and a second start is raised mid-run, so a design that reads live inputs or restarts on a busy start returns the wrong result or pulses `done` at the wrong time. The bench also covers a zero divisor with nonzero upper bits in a short divide, masking of the upper operand bits, back-to-back commands issued in the `done` cycle, and result hold across idle cycles and across operations of the other kind. A design that clears the product on a divide, or forgets to mask, fails the value checks.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam int A_W       = 24;
    localparam int B_W       = 16;
    localparam int P_W       = A_W + B_W;
    localparam int NA_W      = 16;
    localparam int NB_W      = 8;
    localparam int STEP_BITS = 2;
    localparam int CNT_W     = 4;

    localparam int LAT_MUL_S = 5;
    localparam int LAT_MUL_L = 12;
    localparam int LAT_DIV_S = 8;
    localparam int LAT_DIV_L = 12;

    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_L = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_L = 2'b11
    } op_e;

    typedef struct packed {
        logic [P_W-1:0] acc;
        logic [P_W-1:0] mcand;
        logic [B_W-1:0] mplier;
    } mul_st_t;

    typedef struct packed {
        logic [B_W-1:0] rem;
        logic [A_W-1:0] quo;
    } div_st_t;

    function automatic logic op_is_div(input op_e op);
        return op[1];
    endfunction

    function automatic logic op_is_long(input op_e op);
        return op[0];
    endfunction

    // Steps still to run after the acceptance edge, which runs the first one.
    function automatic logic [CNT_W-1:0] steps_left(input op_e op);
        case (op)
            OP_MUL_S: return CNT_W'(LAT_MUL_S - 1);
            OP_MUL_L: return CNT_W'(LAT_MUL_L - 1);
            OP_DIV_S: return CNT_W'(LAT_DIV_S - 1);
            default:  return CNT_W'(LAT_DIV_L - 1);
        endcase
    endfunction

    function automatic mul_st_t mul_step(input mul_st_t s);
        mul_st_t n = s;
        for (int i = 0; i < STEP_BITS; i++) begin
            if (n.mplier[0]) n.acc = n.acc + n.mcand;
            n.mcand  = n.mcand << 1;
            n.mplier = n.mplier >> 1;
        end
        return n;
    endfunction

    function automatic div_st_t div_step(input div_st_t s, input logic [B_W-1:0] dvs);
        div_st_t n = s;
        logic [B_W:0] trial;
        for (int i = 0; i < STEP_BITS; i++) begin
            trial = {n.rem, n.quo[A_W-1]};
            n.quo = {n.quo[A_W-2:0], 1'b0};
            if (trial >= {1'b0, dvs}) begin
                trial    = trial - {1'b0, dvs};
                n.quo[0] = 1'b1;
            end
            n.rem = trial[B_W-1:0];
        end
        return n;
    endfunction

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  op_e  op,
    output logic busy,
    output logic done,
    output logic load,
    output logic step
);

    logic [CNT_W-1:0] remaining;

    assign load = start && !busy;
    assign step = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            remaining <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                remaining <= steps_left(op);
                busy      <= 1'b1;
            end else if (busy) begin
                remaining <= remaining - 1'b1;
                if (remaining == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_not_done_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    assert_busy_ends_in_done_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_busy_needs_start_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core
    import muldiv_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  op_e            op,
    input  logic [A_W-1:0] opa,
    input  logic [B_W-1:0] opb,
    output logic [P_W-1:0] product
);

    mul_st_t st, init;

    always_comb begin
        init.acc = '0;
        if (op_is_long(op)) begin
            init.mcand  = {{(P_W-A_W){1'b0}}, opa};
            init.mplier = opb;
        end else begin
            init.mcand  = {{(P_W-NA_W){1'b0}}, opa[NA_W-1:0]};
            init.mplier = {{(B_W-NB_W){1'b0}}, opb[NB_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       st <= '0;
        else if (load) st <= mul_step(init);
        else if (step) st <= mul_step(st);
    end

    assign product = st.acc;

    assert_mcand_shift_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> st.mcand[STEP_BITS-1:0] == '0);

endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core
    import muldiv_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  op_e            op,
    input  logic [A_W-1:0] opa,
    input  logic [B_W-1:0] opb,
    output logic [A_W-1:0] quotient,
    output logic [B_W-1:0] remainder,
    output logic           div_zero
);

    div_st_t        st, init;
    logic [B_W-1:0] divisor, init_dvs;
    logic           wide;

    always_comb begin
        init.rem = '0;
        if (op_is_long(op)) begin
            init.quo = opa;
            init_dvs = opb;
        end else begin
            init.quo = {opa[NA_W-1:0], {(A_W-NA_W){1'b0}}};
            init_dvs = {{(B_W-NB_W){1'b0}}, opb[NB_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            divisor  <= '0;
            wide     <= 1'b0;
            div_zero <= 1'b0;
        end else if (load) begin
            st       <= div_step(init, init_dvs);
            divisor  <= init_dvs;
            wide     <= op_is_long(op);
            div_zero <= (init_dvs == '0);
        end else if (step) begin
            st <= div_step(st, divisor);
        end
    end

    assign quotient  = wide ? st.quo : {{(A_W-NA_W){1'b0}}, st.quo[NA_W-1:0]};
    assign remainder = wide ? st.rem : {{(B_W-NB_W){1'b0}}, st.rem[NB_W-1:0]};

    assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (rst)
        (divisor != '0) |-> (st.rem < divisor));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  op,
    input  logic [23:0] opa,
    input  logic [15:0] opb,
    output logic        busy,
    output logic        done,
    output logic [39:0] product,
    output logic [23:0] quotient,
    output logic [15:0] remainder,
    output logic        div_zero
);

    op_e  op_in, op_q;
    logic load, step;

    assign op_in = op_e'(op);

    always_ff @(posedge clk) begin
        if (rst)       op_q <= OP_MUL_S;
        else if (load) op_q <= op_in;
    end

    muldiv_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .op    (op_in),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .step  (step)
    );

    muldiv_mul_core u_mul (
        .clk     (clk),
        .rst     (rst),
        .load    (load && !op_is_div(op_in)),
        .step    (step && !op_is_div(op_q)),
        .op      (op_in),
        .opa     (opa),
        .opb     (opb),
        .product (product)
    );

    muldiv_div_core u_div (
        .clk       (clk),
        .rst       (rst),
        .load      (load && op_is_div(op_in)),
        .step      (step && op_is_div(op_q)),
        .op        (op_in),
        .opa       (opa),
        .opb       (opb),
        .quotient  (quotient),
        .remainder (remainder),
        .div_zero  (div_zero)
    );

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !busy && !start) |->
            ($stable(product) && $stable(quotient) && $stable(remainder) && $stable(div_zero)));

    assert_zero_div_ones_R7: assert property (@(posedge clk) disable iff (rst)
        (done && op_is_div(op_q) && div_zero) |->
            (quotient == (op_is_long(op_q) ? {A_W{1'b1}} : {{(A_W-NA_W){1'b0}}, {NA_W{1'b1}}})));

    assert_short_mul_width_R1: assert property (@(posedge clk) disable iff (rst)
        (done && op_q == OP_MUL_S) |-> (product[P_W-1:NA_W+NB_W] == '0));

endmodule

// File: tb/muldiv_unit_tb.sv
`timescale 1ns/1ps
module muldiv_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [23:0] opa = '0;
    logic [15:0] opb = '0;
    logic        busy, done, div_zero;
    logic [39:0] product;
    logic [23:0] quotient;
    logic [15:0] remainder;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    muldiv_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
        .busy(busy), .done(done), .product(product), .quotient(quotient),
        .remainder(remainder), .div_zero(div_zero)
    );

    task automatic chk(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int lat_of(input logic [1:0] o);
        case (o)
            2'b00:   return 5;
            2'b01:   return 12;
            2'b10:   return 8;
            default: return 12;
        endcase
    endfunction

    // Runs one command from a negedge; returns at the negedge where done is expected.
    task automatic run_op(input logic [1:0] o, input logic [23:0] a, input logic [15:0] b,
                          input string req, input bit poke);
        longint unsigned ep, eq, er, ez, dvd, dvs;
        int n = lat_of(o);
        int busy_bad = 0;
        int done_bad = 0;
        ep = product; eq = quotient; er = remainder; ez = div_zero;
        case (o)
            2'b00: ep = longint'(a[15:0]) * longint'(b[7:0]);
            2'b01: ep = longint'(a) * longint'(b);
            default: begin
                dvd = o[0] ? longint'(a) : longint'(a[15:0]);
                dvs = o[0] ? longint'(b) : longint'(b[7:0]);
                if (dvs == 0) begin
                    ez = 1;
                    eq = o[0] ? 64'hFFFFFF : 64'hFFFF;
                    er = o[0] ? (dvd & 64'hFFFF) : (dvd & 64'hFF);
                end else begin
                    ez = 0;
                    eq = dvd / dvs;
                    er = dvd % dvs;
                end
            end
        endcase
        start = 1'b1; op = o; opa = a; opb = b;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (k == 1) begin
                opa = a ^ 24'h5A3C96;
                opb = b ^ 16'hC3A5;
                if (poke) op = ~o;
                else      start = 1'b0;
            end
            if (k == 2) start = 1'b0;
            if (k < n) begin
                if (!busy) busy_bad++;
                if (done)  done_bad++;
            end
        end
        chk("R5", "busy low or early done during run", longint'(busy_bad + done_bad), 0);
        chk(req, "done at latency", longint'(done), 1);
        chk("R5", "busy low in done cycle", longint'(busy), 0);
        chk(req, "product", product, ep);
        chk(req, "quotient", quotient, eq);
        chk(req, "remainder", remainder, er);
        chk(req, "div_zero", longint'(div_zero), ez);
    endtask

    task automatic idle(input int n);
        start = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic test_reset_R9;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", "busy", longint'(busy), 0);
        chk("R9", "done", longint'(done), 0);
        chk("R9", "product", product, 0);
        chk("R9", "quotient", quotient, 0);
        chk("R9", "remainder", remainder, 0);
        chk("R9", "div_zero", longint'(div_zero), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_short_mul_R1;
        run_op(2'b00, 24'h00FFFF, 16'h00FF, "R1", 1'b0); idle(2);
        run_op(2'b00, 24'h001234, 16'h0003, "R1", 1'b0); idle(2);
    endtask

    task automatic test_long_mul_R2;
        run_op(2'b01, 24'hFFFFFF, 16'hFFFF, "R2", 1'b0); idle(2);
        run_op(2'b01, 24'h123456, 16'h0000, "R2", 1'b0); idle(2);
        run_op(2'b01, 24'h800001, 16'h8001, "R2", 1'b0); idle(2);
    endtask

    task automatic test_short_div_R3;
        run_op(2'b10, 24'h00FFFF, 16'h0001, "R3", 1'b0); idle(2);
        run_op(2'b10, 24'h00C351, 16'h00FE, "R3", 1'b0); idle(2);
        run_op(2'b10, 24'h000005, 16'h0009, "R3", 1'b0); idle(2);
    endtask

    task automatic test_long_div_R4;
        run_op(2'b11, 24'hFFFFFF, 16'hFFFF, "R4", 1'b0); idle(2);
        run_op(2'b11, 24'h9ABCDE, 16'h0123, "R4", 1'b0); idle(2);
        run_op(2'b11, 24'h00FFFE, 16'hFFFF, "R4", 1'b0); idle(2);
    endtask

    task automatic test_zero_div_R7;
        run_op(2'b11, 24'hABCDEF, 16'h0000, "R7", 1'b0); idle(2);
        run_op(2'b10, 24'h0042A7, 16'h3300, "R7", 1'b0); idle(2);
        run_op(2'b10, 24'h000064, 16'h0007, "R7", 1'b0); idle(2);
    endtask

    task automatic test_busy_start_R6;
        run_op(2'b01, 24'h3F0A11, 16'h7777, "R6", 1'b1);
        @(negedge clk);
        chk("R6", "no restart after ignored start: done", longint'(done), 0);
        chk("R6", "no restart after ignored start: busy", longint'(busy), 0);
        idle(2);
    endtask

    task automatic test_back_to_back_R5;
        run_op(2'b00, 24'h00ABCD, 16'h00EF, "R5", 1'b0);
        run_op(2'b10, 24'h00FEED, 16'h0011, "R5", 1'b0);
        run_op(2'b11, 24'h765432, 16'h0F0F, "R5", 1'b0);
        @(negedge clk);
        chk("R5", "done drops after pulse", longint'(done), 0);
        idle(2);
    endtask

    task automatic test_upper_ignored_R10;
        run_op(2'b00, 24'hAB1234, 16'hCD56, "R10", 1'b0); idle(2);
        run_op(2'b10, 24'hFF0064, 16'h9907, "R10", 1'b0); idle(2);
    endtask

    task automatic test_hold_R8;
        longint unsigned p0, q0, r0, z0;
        int moved = 0;
        run_op(2'b11, 24'h0F1E2D, 16'h00C3, "R8", 1'b0);
        run_op(2'b01, 24'h000777, 16'h0099, "R8", 1'b0);
        p0 = product; q0 = quotient; r0 = remainder; z0 = div_zero;
        for (int i = 0; i < 6; i++) begin
            opa = 24'h111111 * (i + 3);
            opb = 16'h2222 * (i + 1);
            op  = 2'(i);
            @(negedge clk);
            if (product != p0 || quotient != q0 || remainder != r0 || div_zero != z0 ||
                busy || done) moved++;
        end
        chk("R8", "outputs moved while idle", longint'(moved), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset_R9;
        test_short_mul_R1;
        test_long_mul_R2;
        test_short_div_R3;
        test_long_div_R4;
        test_zero_div_R7;
        test_busy_start_R6;
        test_back_to_back_R5;
        test_upper_ignored_R10;
        test_hold_R8;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule